// File: doc/BRIEF.md
# Prescaled single-channel PWM timer with gated register writes

The block is a one-channel pulse-width timer behind a small register file that software reaches through a plain write strobe, an address and a combinational read-data bus. A power-of-two prescaler divides the input clock into counter ticks. The up-counter runs from zero to a reload value and then wraps. The output is active while the count is above a compare value, and a polarity bit can invert it.

Software must follow a fixed order, because what the block accepts depends on whether it is enabled. The prescaler and polarity can be changed only while the timer is disabled. Reload and compare values are taken only while it is enabled. Each accepted reload or compare write raises its own completion flag two counter ticks later, and that flag stays set until software clears it. While the counter runs, a new reload or compare value reaches the waveform at the next wrap, so a period already in progress is not cut short. Writing zero to the control register stops everything and drives the output to its inactive level.

Top module: `lptim_pwm`

## Requirements
- R1: The configuration register (address 1) holds the prescale exponent P in bits [2:0] and the polarity in bit 3. While enabled, one counter tick occurs every 2^P input clocks, so P = 0 to 7 gives divisors from 1 to 128.
- R2: While running, the counter steps from 0 to the active reload value A and wraps, giving a period of A+1 ticks. The raw output is active while count > C, the active compare value, which gives A−C active ticks per period when C < A and none when C >= A.
- R3: With polarity 1, the output is the inverse of the raw waveform, so it is high for (A+1)−(A−C) ticks of each period.
- R4: A write to the configuration register while the enable bit is 1 is ignored, and the register reads back unchanged.
- R5: Writes to the reload register (address 2) and the compare register (address 3) are ignored while the enable bit is 0. The value reads back unchanged and no completion flag is raised.
- R6: The status register (address 4) has bit 0 for compare done and bit 1 for reload done. A flag is not set on the cycle right after its accepted write, and it sets two counter ticks after that write.
- R7: Writing 1 to bit 0 or bit 1 of the clear register (address 5) clears the matching status flag. A set flag otherwise stays set.
- R8: In the control register (address 0), bit 0 is enable and bit 1 is continuous start. Start takes effect only if the timer is already enabled, and the counter then begins from 0. A read returns {running, enabled} in bits [1:0].
- R9: Writing 0 to the control register clears enable and running and resets the count. The output then sits at its inactive level, which equals the polarity bit.
- R10: A reload or compare value written while the counter runs is used from the next wrap on.
- R11: After reset, every register reads 0 and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| pwm_out | output | 1 | PWM waveform |

## Verification
Some rules are checked by the assertions on every cycle: the configuration stays stable while the timer is enabled, the output sits at the polarity level while disabled, the count never passes the active reload value, a completion flag rises only after a counter tick, and a flag falls only after a clear write. The bench's sweeps cover what needs a whole period or a sequence of writes to show. They measure the high time over whole periods for every prescale exponent and for reload and compare combinations, including compare values at or above reload, under both polarities. They also cover ignored writes in both enable states, completion-flag timing, and a compare value changed mid-run that reaches the waveform only after a wrap.

// File: rtl/lptim_pkg.sv
package lptim_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CFG    = 3'd1;
    localparam logic [ADDR_W-1:0] A_RELOAD = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMP    = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT   = 3'd4;
    localparam logic [ADDR_W-1:0] A_CLR    = 3'd5;
    // bit positions
    localparam int B_EN   = 0;
    localparam int B_RUN  = 1;
    localparam int B_POL  = 3;
    localparam int F_CMP  = 0;
    localparam int F_REL  = 1;
endpackage

// File: rtl/lptim_prescaler.sv
module lptim_prescaler #(
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);
    localparam int DIV_W = (1 << PSC_W) - 1;

    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        for (int i = 0; i < DIV_W; i++) mask[i] = (i < 32'(psc));
        tick  = en && ((div_q & mask) == mask);
        div_d = en ? div_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/lptim_sync.sv
module lptim_sync #(
    parameter int SYNC_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic start,
    input  logic clear,
    output logic ok
);
    localparam int PW = $clog2(SYNC_TICKS + 1);

    typedef struct packed {
        logic [PW-1:0] pend;
        logic          ok;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clear) s_d.ok = 1'b0;
        if (!en) begin
            s_d.pend = '0;
        end else if (start) begin
            s_d.pend = PW'(SYNC_TICKS);
        end else if (tick && s_q.pend != '0) begin
            s_d.pend = s_q.pend - 1'b1;
            if (s_q.pend == PW'(1)) s_d.ok = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ok = s_q.ok;

    a_r6_flag_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ok) |-> $past(tick));
    a_r7_flag_falls_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ok) |-> $past(clear));
endmodule

// File: rtl/lptim_counter.sv
module lptim_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] pre_arr,
    input  logic [CNT_W-1:0] pre_cmp,
    output logic             active
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] arr;
        logic [CNT_W-1:0] cmp;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (!run) begin
            c_d.cnt = '0;
            c_d.arr = pre_arr;
            c_d.cmp = pre_cmp;
        end else if (tick) begin
            if (c_q.cnt == c_q.arr) begin
                c_d.cnt = '0;
                c_d.arr = pre_arr;
                c_d.cmp = pre_cmp;
            end else begin
                c_d.cnt = c_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign active = run && (c_q.cnt > c_q.cmp);

    a_r2_count_within_reload: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (c_q.cnt <= c_q.arr));
endmodule

// File: rtl/lptim_pwm.sv
module lptim_pwm
    import lptim_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int PSC_W      = 3,
    parameter int SYNC_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              pwm_out
);
    typedef struct packed {
        logic             en;
        logic             run;
        logic [PSC_W-1:0] psc;
        logic             pol;
        logic [CNT_W-1:0] arr;
        logic [CNT_W-1:0] cmp;
    } regs_t;

    regs_t r_d, r_q;
    logic  acc_arr, acc_cmp, clr_cmp, clr_rel;
    logic  tick, active, cmp_ok, rel_ok;

    always_comb begin
        r_d     = r_q;
        acc_arr = wr_en && (addr == A_RELOAD) && r_q.en;
        acc_cmp = wr_en && (addr == A_CMP) && r_q.en;
        clr_cmp = wr_en && (addr == A_CLR) && wdata[F_CMP];
        clr_rel = wr_en && (addr == A_CLR) && wdata[F_REL];
        if (wr_en) begin
            case (addr)
                A_CTRL: begin
                    r_d.en  = wdata[B_EN];
                    r_d.run = wdata[B_EN] && (r_q.run || (wdata[B_RUN] && r_q.en));
                end
                A_CFG: if (!r_q.en) begin
                    r_d.psc = wdata[PSC_W-1:0];
                    r_d.pol = wdata[B_POL];
                end
                A_RELOAD: if (r_q.en) r_d.arr = wdata;
                A_CMP:    if (r_q.en) r_d.cmp = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    lptim_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .en(r_q.en), .psc(r_q.psc), .tick(tick));

    lptim_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(r_q.run), .tick(tick),
        .pre_arr(r_q.arr), .pre_cmp(r_q.cmp), .active(active));

    lptim_sync #(.SYNC_TICKS(SYNC_TICKS)) u_sync_cmp (
        .clk(clk), .rst_n(rst_n), .en(r_q.en), .tick(tick),
        .start(acc_cmp), .clear(clr_cmp), .ok(cmp_ok));

    lptim_sync #(.SYNC_TICKS(SYNC_TICKS)) u_sync_rel (
        .clk(clk), .rst_n(rst_n), .en(r_q.en), .tick(tick),
        .start(acc_arr), .clear(clr_rel), .ok(rel_ok));

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:   begin rdata[B_EN] = r_q.en; rdata[B_RUN] = r_q.run; end
            A_CFG:    begin rdata[PSC_W-1:0] = r_q.psc; rdata[B_POL] = r_q.pol; end
            A_RELOAD: rdata = r_q.arr;
            A_CMP:    rdata = r_q.cmp;
            A_STAT:   begin rdata[F_CMP] = cmp_ok; rdata[F_REL] = rel_ok; end
            default:  rdata = '0;
        endcase
    end

    assign pwm_out = r_q.pol ^ active;

    a_r4_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.en |=> ($stable(r_q.psc) && $stable(r_q.pol)));
    a_r9_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.en |-> (pwm_out == r_q.pol));
    a_r8_run_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.run) |-> $past(r_q.en));
endmodule

// File: tb/lptim_pwm_test.sv
module lptim_pwm_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        pwm_out;

    int checks = 0;
    int fails  = 0;

    lptim_pwm uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                   .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out));

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        @(negedge clk);
        addr = a;
        #1 v = int'(rdata);
    endtask

    task automatic measure(input int cycles, output int hi);
        hi = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
    endtask

    function automatic int exp_high(int p, int pol, int a, int c);
        int per, act;
        per = (a + 1) << p;
        act = (c < a) ? ((a - c) << p) : 0;
        return pol ? per - act : act;
    endfunction

    task automatic run_cfg(input int p, input int pol, input int a, input int c);
        int v, hi, per;
        wr(3'd0, 16'd0);
        wr(3'd1, 16'((pol << 3) | p));
        wr(3'd0, 16'd1);
        wr(3'd2, 16'(a));
        wr(3'd3, 16'(c));
        repeat ((4 << p) + 4) @(negedge clk);
        rd(3'd4, v); check("R6 flags set", v, 3);
        wr(3'd5, 16'd3);
        rd(3'd4, v); check("R7 flags cleared", v, 0);
        wr(3'd0, 16'd3);
        rd(3'd0, v); check("R8 running", v, 3);
        per = (a + 1) << p;
        repeat (per + 4) @(negedge clk);
        measure(2 * per, hi);
        check($sformatf("R1 R2 R3 high p=%0d pol=%0d a=%0d c=%0d", p, pol, a, c),
              hi, 2 * exp_high(p, pol, a, c));
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int v, hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v); check($sformatf("R11 reg %0d", a), v, 0);
        end
        check("R11 output", int'(pwm_out), 0);

        // R5 ignored while disabled
        wr(3'd2, 16'd9);
        wr(3'd3, 16'd4);
        repeat (8) @(negedge clk);
        rd(3'd2, v); check("R5 reload ignored", v, 0);
        rd(3'd3, v); check("R5 compare ignored", v, 0);
        rd(3'd4, v); check("R5 no flag", v, 0);

        // R8 start ignored when not enabled first
        wr(3'd0, 16'd3);
        rd(3'd0, v); check("R8 start needs enable", v, 1);

        // R4 cfg ignored while enabled
        wr(3'd1, 16'hF);
        rd(3'd1, v); check("R4 cfg locked", v, 0);

        // R6 flag not immediate (P=2)
        wr(3'd0, 16'd0);
        wr(3'd1, 16'd2);
        wr(3'd0, 16'd1);
        wr(3'd3, 16'd1);
        rd(3'd4, v); check("R6 not immediate", v, 0);
        repeat (16) @(negedge clk);
        rd(3'd4, v); check("R6 cmp flag", v, 1);
        repeat (16) @(negedge clk);
        rd(3'd4, v); check("R7 flag holds", v, 1);
        wr(3'd5, 16'd1);
        rd(3'd4, v); check("R7 clear cmp", v, 0);

        // full prescaler sweep
        for (int p = 0; p < 8; p++) run_cfg(p, p & 1, 5, 2);
        // reload/compare sweep
        for (int p = 0; p < 2; p++)
            for (int ai = 0; ai < 3; ai++) begin
                int a;
                a = (ai == 0) ? 1 : (ai == 1) ? 3 : 6;
                for (int c = 0; c <= a + 1; c++) run_cfg(p, 0, a, c);
            end

        // R10 compare change mid-run: a=5 c=2 -> c=4
        run_cfg(0, 0, 5, 2);
        wr(3'd3, 16'd4);
        repeat (14) @(negedge clk);
        measure(12, hi); check("R10 new compare after wrap", hi, 2);
        wr(3'd2, 16'd7);
        repeat (20) @(negedge clk);
        measure(16, hi); check("R10 new reload after wrap", hi, 6);

        // R9 disable with polarity 1
        run_cfg(1, 1, 3, 1);
        wr(3'd0, 16'd0);
        rd(3'd0, v); check("R9 ctrl cleared", v, 0);
        measure(10, hi); check("R9 idle level pol=1", hi, 10);
        wr(3'd1, 16'd0);
        measure(10, hi); check("R9 idle level pol=0", hi, 0);
        // restart begins from 0: first active tick after c+1 ticks
        wr(3'd0, 16'd1);
        wr(3'd2, 16'd3);
        wr(3'd3, 16'd1);
        wr(3'd0, 16'd3);
        measure(8, hi); check("R9 restart period", hi, 4);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule